// File: doc/BRIEF.md
# SWD Transaction Retry Controller

This block sits between a queue of debug-port register requests and a low-level serial wire debug engine that shifts bits on the wire. Each request is a register read, a register write or a batch flush. For a read or write the controller builds the 8-bit request header, hands it to the engine with the write data, the write parity and a trailing idle count, and then handles the three-bit acknowledge that the engine returns.

An OK acknowledge finishes the request. A read returns its data only when the received parity bit matches the data. A WAIT acknowledge starts recovery: the controller writes the sticky-error clear flags to the DP abort register and then issues the original request again, up to a configurable number of times. FAULT, undefined codes, a parity mismatch and an exhausted retry budget each latch an error status. While that status is held, later reads and writes are accepted and thrown away. A flush clocks idle cycles onto the wire, reports the held status and returns it to OK.

The request input and the response output are valid/ready streams. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only while the controller has nothing in flight and no response waiting. Once `rsp_valid` rises it stays high, with its payload unchanged, until the cycle on which `rsp_ready` is high. The engine side is plain control: a one-cycle start pulse, with the command held stable until a one-cycle done pulse that carries the result.

Top module: `swd_retry_ctrl`

## Requirements
- R1: Every read or write the engine receives has header bit 0 = 1 and bit 7 = 1 (start and park), bit 6 = 0, bit 1 = AP select, bit 2 = read, bits 4:3 = register address, and bit 5 = even parity over bits 4:1.
- R2: An AP access passes its requested idle count (0 to 255) to the engine. A DP access always passes an idle count of 0, whatever the request field holds.
- R3: For a write, the engine receives the write data and a parity bit equal to the XOR of its 32 bits.
- R4: A read whose acknowledge is OK (3'b001, first received bit in the LSB) and whose parity bit equals the XOR of the read data produces one response with `rsp_is_flush` = 0, status 4'b0001 and that data.
- R5: A read with an OK acknowledge and a mismatched parity bit produces no response and latches status 4'b1000.
- R6: A WAIT acknowledge (3'b010) causes a DP write with header 8'h81, data 32'h0000001E, parity 0 and idle 0. If that write is acknowledged OK, the original request is issued again unchanged.
- R7: A request may receive WAIT RETRY_LIMIT times (default 3) and still be retried. The next WAIT latches status 4'b1001 with no further abort write.
- R8: A FAULT (3'b100) or any other code that is not OK or WAIT, received on a request or on its abort write, ends the request and latches status {1'b0, ack}.
- R9: While the latched status is not 4'b0001, read and write requests are accepted but start no engine operation and produce no response.
- R10: A flush (`req_op` bit 1 = 1) runs an idle-only engine operation of 8 cycles. It then produces a response with `rsp_is_flush` = 1 and the latched status, and the status returns to 4'b0001.
- R11: Once `rsp_valid` is high it stays high with a stable payload until `rsp_ready` is high, and no request is accepted before then.
- R12: After reset `req_ready` = 1, `rsp_valid` = 0, `eng_start` = 0 and the latched status is 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | 0 write, 1 read, 2 or 3 flush |
| req_ap | input | 1 | 1 selects an AP register, 0 a DP register |
| req_addr | input | 2 | Register address bits 3:2 |
| req_wdata | input | 32 | Write data |
| req_ap_idle | input | 8 | Idle cycles after an AP access |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken this cycle when valid |
| rsp_is_flush | output | 1 | Response belongs to a flush |
| rsp_status | output | 4 | Status of the response |
| rsp_rdata | output | 32 | Read data (0 for flush) |
| eng_start | output | 1 | One-cycle engine start pulse |
| eng_idle_only | output | 1 | Engine clocks idle cycles only |
| eng_header | output | 8 | Request header for the engine |
| eng_wdata | output | 32 | Write data for the engine |
| eng_wparity | output | 1 | Parity of eng_wdata |
| eng_idle_cnt | output | 8 | Idle cycles after the operation |
| eng_done | input | 1 | One-cycle engine completion pulse |
| eng_ack | input | 3 | Acknowledge, first received bit in the LSB |
| eng_rdata | input | 32 | Read data from the engine |
| eng_rparity | input | 1 | Received read parity bit |

## Verification
The hardest situation to reach is the far edge of the retry budget: a single request must collect exactly RETRY_LIMIT WAIT answers, each followed by an accepted abort write, and then one more WAIT. A second hard case is an abort write that itself fails. The bench engine model answers from a scripted acknowledge list that is written out per request. This lets it build long WAIT chains, a failing abort, undefined codes and bad read parity on demand. Each latched error is then followed by reads and writes that must vanish, and a flush that must report the exact code. The response ready line is throttled on a fixed pattern, so every response also passes through back-pressure.

// File: rtl/swd_rc_pkg.sv
package swd_rc_pkg;
  localparam int unsigned ACK_W  = 3;
  localparam int unsigned ST_W   = 4;
  localparam int unsigned HDR_W  = 8;
  localparam int unsigned REG_AW = 2;

  localparam logic [ACK_W-1:0] ACK_OK    = 3'b001;
  localparam logic [ACK_W-1:0] ACK_WAIT  = 3'b010;
  localparam logic [ACK_W-1:0] ACK_FAULT = 3'b100;

  localparam logic [ST_W-1:0] ST_OK      = 4'b0001;
  localparam logic [ST_W-1:0] ST_PARITY  = 4'b1000;
  localparam logic [ST_W-1:0] ST_TIMEOUT = 4'b1001;

  // bit positions of the sticky-clear flags in the DP abort register
  localparam int unsigned CLR_CMP_BIT  = 1;
  localparam int unsigned CLR_ERR_BIT  = 2;
  localparam int unsigned CLR_WDE_BIT  = 3;
  localparam int unsigned CLR_ORUN_BIT = 4;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_FLUSH = 2'd2,
    OP_FLUSH_ALT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    OC_DONE,
    OC_DATA,
    OC_WAIT,
    OC_ERR
  } outcome_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_GO,
    S_BUSY,
    S_AB_GO,
    S_AB_BUSY,
    S_FL_GO,
    S_FL_BUSY,
    S_RESP
  } state_e;
endpackage

// File: rtl/swd_rc_hdr.sv
module swd_rc_hdr
  import swd_rc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              is_ap,
  input  logic              is_read,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [HDR_W-1:0]  header,
  output logic              wparity
);
  logic hdr_par;

  always_comb begin
    hdr_par = ^{addr, is_read, is_ap};
    // park, stop, parity, address, read, ap, start
    header  = {1'b1, 1'b0, hdr_par, addr, is_read, is_ap, 1'b1};
    wparity = ^wdata;
  end
endmodule

// File: rtl/swd_rc_ackcls.sv
module swd_rc_ackcls
  import swd_rc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [ACK_W-1:0]  ack,
  input  logic              is_read,
  input  logic              is_abort,
  input  logic [DATA_W-1:0] rdata,
  input  logic              rparity,
  output outcome_e          outcome,
  output logic [ST_W-1:0]   err_code
);
  logic par_good;

  always_comb begin
    par_good = (rparity == (^rdata));
    outcome  = OC_ERR;
    err_code = {1'b0, ack};
    if (ack == ACK_OK) begin
      if (is_read && !is_abort) begin
        if (par_good) begin
          outcome  = OC_DATA;
          err_code = ST_OK;
        end else begin
          outcome  = OC_ERR;
          err_code = ST_PARITY;
        end
      end else begin
        outcome  = OC_DONE;
        err_code = ST_OK;
      end
    end else if (ack == ACK_WAIT && !is_abort) begin
      outcome  = OC_WAIT;
      err_code = ST_OK;
    end
  end
endmodule

// File: rtl/swd_rc_waitcnt.sv
module swd_rc_waitcnt #(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 2);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit = (cnt_q == LIM_V);

  AST_WAIT_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_V);  // R7
  AST_NO_INC_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_limit);  // R7
endmodule

// File: rtl/swd_retry_ctrl.sv
module swd_retry_ctrl
  import swd_rc_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned IDLE_W      = 8,
  parameter int unsigned FLUSH_IDLE  = 8,
  parameter int unsigned RETRY_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_ap,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [IDLE_W-1:0] req_ap_idle,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_is_flush,
  output logic [3:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              eng_start,
  output logic              eng_idle_only,
  output logic [7:0]        eng_header,
  output logic [DATA_W-1:0] eng_wdata,
  output logic              eng_wparity,
  output logic [IDLE_W-1:0] eng_idle_cnt,
  input  logic              eng_done,
  input  logic [2:0]        eng_ack,
  input  logic [DATA_W-1:0] eng_rdata,
  input  logic              eng_rparity
);
  localparam logic [DATA_W-1:0] ABORT_DATA =
    (DATA_W'(1) << CLR_CMP_BIT) | (DATA_W'(1) << CLR_ERR_BIT) |
    (DATA_W'(1) << CLR_WDE_BIT) | (DATA_W'(1) << CLR_ORUN_BIT);
  localparam logic [IDLE_W-1:0] FLUSH_CNT = IDLE_W'(FLUSH_IDLE);

  state_e              state_q;
  logic                rq_ap, rq_rd;
  logic [1:0]          rq_addr;
  logic [DATA_W-1:0]   rq_wdata;
  logic [IDLE_W-1:0]   rq_idle;
  logic [ST_W-1:0]     status_q;
  logic [DATA_W-1:0]   rsp_data_q;
  logic [ST_W-1:0]     rsp_status_q;
  logic                rsp_flush_q;

  logic [HDR_W-1:0]    rq_hdr, ab_hdr;
  logic                rq_wpar, ab_wpar;
  outcome_e            outcome;
  logic [ST_W-1:0]     err_code;
  logic                at_limit, cnt_clr, cnt_inc;
  logic                in_abort, in_flush, accept;

  // header and parity for the queued request and for the abort write
  swd_rc_hdr #(.DATA_W(DATA_W)) u_hdr_req (
    .is_ap(rq_ap), .is_read(rq_rd), .addr(rq_addr), .wdata(rq_wdata),
    .header(rq_hdr), .wparity(rq_wpar)
  );
  swd_rc_hdr #(.DATA_W(DATA_W)) u_hdr_abort (
    .is_ap(1'b0), .is_read(1'b0), .addr(2'b00), .wdata(ABORT_DATA),
    .header(ab_hdr), .wparity(ab_wpar)
  );

  swd_rc_ackcls #(.DATA_W(DATA_W)) u_ackcls (
    .ack(eng_ack), .is_read(rq_rd), .is_abort(state_q == S_AB_BUSY),
    .rdata(eng_rdata), .rparity(eng_rparity),
    .outcome(outcome), .err_code(err_code)
  );

  swd_rc_waitcnt #(.LIMIT(RETRY_LIMIT)) u_waitcnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .at_limit(at_limit)
  );

  always_comb begin
    accept   = (state_q == S_IDLE) && req_valid;
    in_abort = (state_q == S_AB_GO) || (state_q == S_AB_BUSY);
    in_flush = (state_q == S_FL_GO) || (state_q == S_FL_BUSY);
    cnt_clr  = accept;
    cnt_inc  = (state_q == S_BUSY) && eng_done && (outcome == OC_WAIT) && !at_limit;
  end

  // request and response stream pins
  assign req_ready    = (state_q == S_IDLE);
  assign rsp_valid    = (state_q == S_RESP);
  assign rsp_is_flush = rsp_flush_q;
  assign rsp_status   = rsp_status_q;
  assign rsp_rdata    = rsp_data_q;

  // engine command: held stable for the whole operation
  always_comb begin
    eng_start     = (state_q == S_GO) || (state_q == S_AB_GO) || (state_q == S_FL_GO);
    eng_idle_only = in_flush;
    eng_header    = in_abort ? ab_hdr     : rq_hdr;
    eng_wdata     = in_abort ? ABORT_DATA : rq_wdata;
    eng_wparity   = in_abort ? ab_wpar    : rq_wpar;
    if (in_flush)               eng_idle_cnt = FLUSH_CNT;
    else if (in_abort || !rq_ap) eng_idle_cnt = '0;
    else                        eng_idle_cnt = rq_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      rq_ap        <= 1'b0;
      rq_rd        <= 1'b0;
      rq_addr      <= '0;
      rq_wdata     <= '0;
      rq_idle      <= '0;
      status_q     <= ST_OK;
      rsp_data_q   <= '0;
      rsp_status_q <= ST_OK;
      rsp_flush_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          rq_ap    <= req_ap;
          rq_rd    <= (req_op == OP_READ);
          rq_addr  <= req_addr;
          rq_wdata <= req_wdata;
          rq_idle  <= req_ap_idle;
          if (req_op[1])              state_q <= S_FL_GO;
          else if (status_q != ST_OK) state_q <= S_IDLE;
          else                        state_q <= S_GO;
        end
        S_GO: state_q <= S_BUSY;
        S_BUSY: if (eng_done) begin
          case (outcome)
            OC_DATA: begin
              rsp_data_q   <= eng_rdata;
              rsp_status_q <= ST_OK;
              rsp_flush_q  <= 1'b0;
              state_q      <= S_RESP;
            end
            OC_DONE: state_q <= S_IDLE;
            OC_WAIT: begin
              if (at_limit) begin
                status_q <= ST_TIMEOUT;
                state_q  <= S_IDLE;
              end else begin
                state_q  <= S_AB_GO;
              end
            end
            default: begin
              status_q <= err_code;
              state_q  <= S_IDLE;
            end
          endcase
        end
        S_AB_GO: state_q <= S_AB_BUSY;
        S_AB_BUSY: if (eng_done) begin
          if (outcome == OC_DONE) begin
            state_q <= S_GO;
          end else begin
            status_q <= err_code;
            state_q  <= S_IDLE;
          end
        end
        S_FL_GO: state_q <= S_FL_BUSY;
        S_FL_BUSY: if (eng_done) begin
          rsp_status_q <= status_q;
          rsp_flush_q  <= 1'b1;
          rsp_data_q   <= '0;
          status_q     <= ST_OK;
          state_q      <= S_RESP;
        end
        S_RESP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_DP_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && !eng_idle_only && !eng_header[1]) |-> (eng_idle_cnt == '0));  // R2
  AST_RETRY_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_AB_BUSY && eng_done && eng_ack == ACK_OK)
      |=> (eng_start && !eng_idle_only && eng_header == rq_hdr));  // R6
  AST_DROP_WHEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_op[1] && status_q != ST_OK) |=> (!eng_start && !rsp_valid));  // R9
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FL_BUSY && eng_done)
      |=> (rsp_valid && rsp_is_flush && status_q == ST_OK));  // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)
      && $stable(rsp_status) && $stable(rsp_is_flush)));  // R11
  AST_NO_ACCEPT_WHILE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);  // R11
  AST_DATA_RSP_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_is_flush) |-> (rsp_status == ST_OK));  // R4
endmodule

// File: tb/test_swd_retry_ctrl.sv
module test_swd_retry_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 3;
  localparam int ENG_LAT    = 3;
  localparam int WD_CYCLES  = 100000;

  localparam logic [2:0] K_OK = 3'b001, K_WAIT = 3'b010, K_FAULT = 3'b100;
  localparam logic [3:0] S_OKV = 4'b0001, S_PAR = 4'b1000, S_TMO = 4'b1001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = 2'd0;
  logic req_ap = 1'b0;
  logic [1:0] req_addr = 2'd0;
  logic [31:0] req_wdata = '0;
  logic [7:0] req_ap_idle = '0;
  logic rsp_valid, rsp_ready = 1'b0, rsp_is_flush;
  logic [3:0] rsp_status;
  logic [31:0] rsp_rdata;
  logic eng_start, eng_idle_only, eng_wparity;
  logic [7:0] eng_header, eng_idle_cnt;
  logic [31:0] eng_wdata;
  logic eng_done = 1'b0;
  logic [2:0] eng_ack = 3'b000;
  logic [31:0] eng_rdata = '0;
  logic eng_rparity = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  swd_retry_ctrl #(.RETRY_LIMIT(LIMIT)) i_swd_retry_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_ap(req_ap), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ap_idle(req_ap_idle), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_is_flush(rsp_is_flush), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .eng_start(eng_start), .eng_idle_only(eng_idle_only), .eng_header(eng_header),
    .eng_wdata(eng_wdata), .eng_wparity(eng_wparity), .eng_idle_cnt(eng_idle_cnt),
    .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
    .eng_rparity(eng_rparity)
  );

  typedef struct packed {
    logic        io;
    logic [7:0]  hdr;
    logic [31:0] wd;
    logic        wp;
    logic [7:0]  ic;
  } eng_exp_t;
  typedef struct packed {
    logic        fl;
    logic [3:0]  st;
    logic [31:0] d;
  } rsp_exp_t;

  eng_exp_t exp_eng[$];
  string    exp_etag[$];
  rsp_exp_t exp_rsp[$];
  string    exp_rtag[$];
  logic [2:0]  scr_ack[$];
  logic [31:0] scr_rd[$];
  logic        scr_rp[$];
  logic [2:0]  plan_ack[$];

  int checks = 0, failures = 0;
  int starts = 0, rsps = 0;
  logic [3:0] m_status = 4'b0001;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_hdr(input logic ap, input logic rd, input logic [1:0] a);
    logic p;
    p = ap ^ rd ^ a[0] ^ a[1];
    return {1'b1, 1'b0, p, a[1], a[0], rd, ap, 1'b1};
  endfunction

  task automatic pa(input logic [2:0] k);
    plan_ack.push_back(k);
  endtask

  // behavioural reference: expected engine operations and responses
  task automatic model(input logic [1:0] op, input logic ap, input logic [1:0] a,
                       input logic [31:0] wd, input logic [7:0] idl,
                       input logic [31:0] rdv, input logic flip, input string tag);
    eng_exp_t e;
    rsp_exp_t r;
    logic rd;
    int waits;
    logic [2:0] k;
    rd = (op == 2'd1);
    if (op[1]) begin
      e = '{io: 1'b1, hdr: '0, wd: '0, wp: 1'b0, ic: 8'd8};
      exp_eng.push_back(e); exp_etag.push_back("R10");
      r = '{fl: 1'b1, st: m_status, d: '0};
      exp_rsp.push_back(r); exp_rtag.push_back(tag);
      m_status = S_OKV;
      return;
    end
    if (m_status != S_OKV) begin
      plan_ack.delete();
      return;
    end
    waits = 0;
    forever begin
      e = '{io: 1'b0, hdr: mk_hdr(ap, rd, a), wd: wd, wp: ^wd, ic: ap ? idl : 8'd0};
      exp_eng.push_back(e); exp_etag.push_back(tag);
      k = plan_ack.pop_front();
      scr_ack.push_back(k); scr_rd.push_back(rdv); scr_rp.push_back((^rdv) ^ flip);
      if (k == K_OK) begin
        if (rd) begin
          if (flip) m_status = S_PAR;
          else begin
            r = '{fl: 1'b0, st: S_OKV, d: rdv};
            exp_rsp.push_back(r); exp_rtag.push_back("R4");
          end
        end
        break;
      end else if (k == K_WAIT) begin
        if (waits == LIMIT) begin
          m_status = S_TMO;
          break;
        end
        waits++;
        e = '{io: 1'b0, hdr: 8'h81, wd: 32'h0000001E, wp: 1'b0, ic: 8'd0};
        exp_eng.push_back(e); exp_etag.push_back("R6");
        k = plan_ack.pop_front();
        scr_ack.push_back(k); scr_rd.push_back('0); scr_rp.push_back(1'b0);
        if (k != K_OK) begin
          m_status = {1'b0, k};
          break;
        end
      end else begin
        m_status = {1'b0, k};
        break;
      end
    end
    plan_ack.delete();
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    while (exp_eng.size() != 0 || exp_rsp.size() != 0 || !req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op, input logic ap, input logic [1:0] a,
                      input logic [31:0] wd, input logic [7:0] idl,
                      input logic [31:0] rdv, input logic flip, input string tag);
    bit seen;
    model(op, ap, a, wd, idl, rdv, flip, tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_ap = ap; req_addr = a;
    req_wdata = wd; req_ap_idle = idl;
    forever begin
      seen = req_ready;
      @(negedge clk);
      if (seen) break;
    end
    req_valid = 1'b0;
    settle();
  endtask

  // engine model and per-clock comparison of engine commands
  initial begin
    int cd;
    logic [2:0] pk;
    logic [31:0] pd;
    logic pp;
    eng_exp_t e;
    string t;
    bit ok;
    cd = 0; pk = K_OK; pd = '0; pp = 1'b0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (rst_n) begin
        if (cd > 0) begin
          cd--;
          if (cd == 0) begin
            eng_done = 1'b1; eng_ack = pk; eng_rdata = pd; eng_rparity = pp;
          end
        end
        if (eng_start) begin
          starts++;
          if (exp_eng.size() == 0) begin
            chk(1'b0, "R9", "unexpected engine start hdr", {56'd0, eng_header}, 64'd0);
            pk = K_OK; pd = '0; pp = 1'b0;
          end else begin
            e = exp_eng.pop_front();
            t = exp_etag.pop_front();
            if (e.io) ok = eng_idle_only && (eng_idle_cnt == e.ic);
            else ok = !eng_idle_only && (eng_header == e.hdr) && (eng_idle_cnt == e.ic)
                      && (e.hdr[2] || ((eng_wdata == e.wd) && (eng_wparity == e.wp)));
            chk(ok, t, "engine hdr/idle/wdata/wpar",
                {eng_idle_only, eng_header, eng_idle_cnt, eng_wparity, eng_wdata},
                {e.io, e.hdr, e.ic, e.wp, e.wd});
            if (e.io) begin pk = K_OK; pd = '0; pp = 1'b0; end
            else begin
              pk = scr_ack.pop_front(); pd = scr_rd.pop_front(); pp = scr_rp.pop_front();
            end
          end
          cd = ENG_LAT;
        end
      end
    end
  end

  // response ready throttle, response comparison and hold check
  initial begin
    int cyc;
    logic pv, pr, pf;
    logic [3:0] ps;
    logic [31:0] pd;
    rsp_exp_t r;
    string t;
    cyc = 0; pv = 1'b0; pr = 1'b0; pf = 1'b0; ps = '0; pd = '0;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_ready = (cyc % 3) != 1;
      if (rst_n) begin
        if (pv && !pr)
          chk(rsp_valid && rsp_is_flush == pf && rsp_status == ps && rsp_rdata == pd,
              "R11", "response hold", {27'd0, rsp_valid, rsp_is_flush, rsp_status, rsp_rdata},
              {27'd0, 1'b1, pf, ps, pd});
        if (rsp_valid && rsp_ready) begin
          rsps++;
          if (exp_rsp.size() == 0) chk(1'b0, "R9", "unexpected response", {32'd0, rsp_rdata}, 64'd0);
          else begin
            r = exp_rsp.pop_front();
            t = exp_rtag.pop_front();
            chk(rsp_is_flush == r.fl && rsp_status == r.st && rsp_rdata == r.d, t,
                "response flush/status/data", {27'd0, rsp_is_flush, rsp_status, rsp_rdata},
                {27'd0, r.fl, r.st, r.d});
          end
        end
      end
      pv = rsp_valid; pr = rsp_ready; pf = rsp_is_flush; ps = rsp_status; pd = rsp_rdata;
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s0, r0;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !eng_start, "R12", "reset outputs",
        {61'd0, req_ready, rsp_valid, eng_start}, 64'd4);
    rst_n = 1'b1;
    @(negedge clk);
    // status after reset is OK: first flush reports 0001
    send(2'd2, 1'b0, 2'd0, '0, '0, '0, 1'b0, "R12");
    // DP write: header fields, parity, zero idle
    pa(K_OK); send(2'd0, 1'b0, 2'd1, 32'hA5A5_0F0F, 8'd9, '0, 1'b0, "R1");
    pa(K_OK); send(2'd0, 1'b1, 2'd2, 32'h0000_0007, 8'd255, '0, 1'b0, "R3");
    // AP read with idle, good parity
    pa(K_OK); send(2'd1, 1'b1, 2'd3, '0, 8'd5, 32'hDEAD_BEEF, 1'b0, "R2");
    pa(K_OK); send(2'd1, 1'b0, 2'd2, '0, 8'd77, 32'h1234_5671, 1'b0, "R2");
    // WAIT, abort OK, retry OK
    pa(K_WAIT); pa(K_OK); pa(K_OK);
    send(2'd1, 1'b1, 2'd1, '0, 8'd3, 32'h0BAD_F00D, 1'b0, "R6");
    pa(K_WAIT); pa(K_OK); pa(K_WAIT); pa(K_OK); pa(K_OK);
    send(2'd0, 1'b1, 2'd0, 32'hFFFF_0001, 8'd1, '0, 1'b0, "R6");
    send(2'd2, 1'b0, 2'd0, '0, '0, '0, 1'b0, "R10");
    // parity mismatch, then dropped requests
    pa(K_OK); send(2'd1, 1'b0, 2'd0, '0, '0, 32'h8000_0001, 1'b1, "R5");
    s0 = starts; r0 = rsps;
    pa(K_OK); send(2'd1, 1'b1, 2'd1, '0, 8'd2, 32'h5555_5555, 1'b0, "R9");
    pa(K_OK); send(2'd0, 1'b0, 2'd3, 32'h1, '0, '0, 1'b0, "R9");
    chk(starts == s0 && rsps == r0, "R9", "dropped requests activity",
        {32'(starts - s0), 32'(rsps - r0)}, 64'd0);
    send(2'd2, 1'b0, 2'd0, '0, '0, '0, 1'b0, "R5");
    // retry budget: LIMIT waits retried, next one times out
    for (int i = 0; i < LIMIT; i++) begin pa(K_WAIT); pa(K_OK); end
    pa(K_WAIT);
    send(2'd0, 1'b1, 2'd2, 32'hCAFE_0000, 8'd4, '0, 1'b0, "R7");
    send(2'd3, 1'b0, 2'd0, '0, '0, '0, 1'b0, "R7");
    // exactly LIMIT waits then success
    for (int i = 0; i < LIMIT; i++) begin pa(K_WAIT); pa(K_OK); end
    pa(K_OK);
    send(2'd1, 1'b0, 2'd1, '0, '0, 32'h0000_00FF, 1'b0, "R7");
    // fault, undefined ack, failing abort
    pa(K_FAULT); send(2'd0, 1'b0, 2'd2, 32'h3, '0, '0, 1'b0, "R8");
    send(2'd2, 1'b0, 2'd0, '0, '0, '0, 1'b0, "R8");
    pa(3'b111); send(2'd1, 1'b1, 2'd0, '0, 8'd6, 32'h7, 1'b0, "R8");
    send(2'd2, 1'b0, 2'd0, '0, '0, '0, 1'b0, "R8");
    pa(K_WAIT); pa(K_FAULT); send(2'd1, 1'b0, 2'd3, '0, '0, 32'h9, 1'b0, "R8");
    send(2'd2, 1'b0, 2'd0, '0, '0, '0, 1'b0, "R8");
    pa(K_OK); send(2'd0, 1'b0, 2'd0, 32'h1E, '0, '0, 1'b0, "R10");
    send(2'd2, 1'b0, 2'd0, '0, '0, '0, 1'b0, "R10");
    chk(exp_eng.size() == 0 && exp_rsp.size() == 0, "R10", "outstanding expectations",
        {32'(exp_eng.size()), 32'(exp_rsp.size())}, 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule